// File: doc/BRIEF.md
# Shared-Memory Doorbell Register Block

This block is the register front end that lets several nodes sharing one memory region signal each other. Software reaches it through a simple 32-bit read/write bus decoded over a 1 KB window that holds four word registers. A write to the doorbell register launches an outgoing request that names a destination node and a vector. Incoming events from peers either latch a status bit that drives a level interrupt, or produce a one-cycle vector pulse.

A mode input picks how events are handled. In pin mode, an incoming event sets the status bit. The interrupt pin follows status gated by bit 0 of the mask, and the vector field of an outgoing request is forced to zero. In vector mode, no status is kept. A valid incoming vector becomes a one-hot pulse. A vector at or above the configured count is dropped and sets a sticky error flag. The position register returns the assigned node ID only while the ready input is high.

The outgoing request is a valid/ready stream with a one-entry slot. A request holds its fields steady until it is accepted. A doorbell write that finds the slot full, with no acceptance in that cycle, is dropped. The incoming event stream never applies back-pressure.

Top module: `shm_doorbell_regs`

## Requirements
- R1: Register reads return data on `bus_rdata` one cycle after `bus_rd`. Word offsets are fixed: byte 0 is the mask (all 32 bits read back), byte 4 is status (reads 0 or 1), byte 8 is the position, and byte 12 is the doorbell (reads 0). Address bits [1:0] are ignored.
- R2: Within the window, byte offsets 16 and above read as 0 and ignore writes.
- R3: After reset, the mask and status are 0, and `irq_pin`, `db_valid`, `msi_pulse` and `vec_err` are all low.
- R4: In pin mode (`msi_mode`=0), an accepted event sets status to 1. Any write to offset 4 clears it. If an event and a clear fall in the same cycle, the event wins.
- R5: `irq_pin` is a register loaded with mask bit 0 AND status, so it follows a change in either one cycle later. Mask bits 31..1 have no effect on it.
- R6: While `dev_ready`=1, the position reads as `node_id` zero-extended. While `dev_ready`=0, it reads as 0xFFFFFFFF. Writes to it are ignored.
- R7: A doorbell write raises `db_valid` in the next cycle. The request carries `db_dest`=wdata[31:16]. `db_vector` is wdata[15:0] in vector mode and 0 in pin mode.
- R8: While `db_valid`=1 and `db_ready`=0, the request fields are held and a new doorbell write is dropped. A write in a cycle where the pending request is accepted loads the new request. An acceptance with no write clears `db_valid`.
- R9: In vector mode, an event with vector v < NUM_VEC drives `msi_pulse` to the one-hot value with bit v set, for exactly the next cycle. Status is not changed.
- R10: In vector mode, an event with vector at or above NUM_VEC produces no pulse and sets `vec_err`. `vec_err` stays high until reset.
- R11: `ev_ready` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| msi_mode | input | 1 | 1 = vector mode, 0 = pin mode |
| dev_ready | input | 1 | Block ready; gates the position value |
| node_id | input | ID_W | Assigned node ID |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | AW | Byte address in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| db_valid | output | 1 | Outgoing request valid |
| db_ready | input | 1 | Outgoing request accepted |
| db_dest | output | 16 | Destination node ID |
| db_vector | output | 16 | Vector to raise at the destination |
| ev_valid | input | 1 | Incoming peer event |
| ev_ready | output | 1 | Always 1 |
| ev_vector | input | 16 | Vector of the incoming event |
| irq_pin | output | 1 | Level interrupt (pin mode) |
| msi_pulse | output | NUM_VEC | One-hot vector pulse |
| vec_err | output | 1 | Sticky out-of-range vector flag |

## Verification
Read data, status, the doorbell slot, `msi_pulse` and `vec_err` are all due one clock after the edge that samples the stimulus. `irq_pin` is due a second clock later, because it is registered from mask and status. The bench drives inputs on falling edges and samples one falling edge after the stimulus edge for every single-register result. For the interrupt pin it waits one further falling edge, so each check lands on the cycle in which the result first becomes visible.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
  localparam int WORD_W  = 32;
  localparam int FIELD_W = 16;

  // Word select; the order is fixed by the register offsets.
  typedef enum logic [1:0] {
    SEL_MASK = 2'd0,
    SEL_STAT = 2'd1,
    SEL_POS  = 2'd2,
    SEL_BELL = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic     hit;
    reg_sel_e sel;
  } dec_t;
endpackage

// File: rtl/dbell_decode.sv
module dbell_decode
  import dbell_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic [AW-1:0] addr,
  output dec_t          dec
);
  // Only the first four words are populated (R2).
  always_comb begin
    dec.hit = (addr[AW-1:4] == '0);
    dec.sel = reg_sel_e'(addr[3:2]);
  end
endmodule

// File: rtl/dbell_irq.sv
module dbell_irq
  import dbell_pkg::*;
#(
  parameter int NUM_VEC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               msi_mode,
  input  logic               mask_we,
  input  logic [WORD_W-1:0]  mask_wdata,
  input  logic               stat_clr,
  input  logic               ev_valid,
  input  logic [FIELD_W-1:0] ev_vector,
  output logic [WORD_W-1:0]  mask_q,
  output logic               status_q,
  output logic               irq_pin,
  output logic [NUM_VEC-1:0] msi_pulse,
  output logic               vec_err
);
  localparam logic [FIELD_W-1:0] NV = FIELD_W'(NUM_VEC);

  logic               ev_pin, ev_msi, in_range;
  logic [NUM_VEC-1:0] pulse_d;

  assign ev_pin   = ev_valid & ~msi_mode;
  assign ev_msi   = ev_valid & msi_mode;
  assign in_range = (ev_vector < NV);

  for (genvar g = 0; g < NUM_VEC; g++) begin : g_pulse
    assign pulse_d[g] = ev_msi && (ev_vector == FIELD_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q    <= '0;
      status_q  <= 1'b0;
      irq_pin   <= 1'b0;
      msi_pulse <= '0;
      vec_err   <= 1'b0;
    end else begin
      if (mask_we) mask_q <= mask_wdata;
      if (ev_pin)        status_q <= 1'b1;
      else if (stat_clr) status_q <= 1'b0;
      irq_pin   <= mask_q[0] & status_q;
      msi_pulse <= pulse_d;
      if (ev_msi && !in_range) vec_err <= 1'b1;
    end
  end

  a_r4_pin_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pin |=> status_q);
  a_r9_status_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_msi && !stat_clr) |=> $stable(status_q));
  a_r9_pulse_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(msi_pulse));
  a_r9_pulse_from_event: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_pulse != '0) |-> $past(ev_msi));
  a_r10_oob_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_msi && !in_range) |=> (msi_pulse == '0) && vec_err);
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    vec_err |=> vec_err);
endmodule

// File: rtl/dbell_outq.sv
module dbell_outq
  import dbell_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FIELD_W-1:0] dest_in,
  input  logic [FIELD_W-1:0] vec_in,
  input  logic               db_ready,
  output logic               db_valid,
  output logic [FIELD_W-1:0] db_dest,
  output logic [FIELD_W-1:0] db_vector
);
  logic free;
  assign free = ~db_valid | db_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      db_valid  <= 1'b0;
      db_dest   <= '0;
      db_vector <= '0;
    end else if (load && free) begin
      db_valid  <= 1'b1;
      db_dest   <= dest_in;
      db_vector <= vec_in;
    end else if (db_valid && db_ready) begin
      db_valid  <= 1'b0;
    end
  end

  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (db_valid && !db_ready) |=> db_valid && $stable(db_dest) && $stable(db_vector));
  a_r7_load_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !db_valid) |=> db_valid);
endmodule

// File: rtl/shm_doorbell_regs.sv
module shm_doorbell_regs
  import dbell_pkg::*;
#(
  parameter int WIN_BYTES = 1024,
  parameter int NUM_VEC   = 8,
  parameter int ID_W      = 16,
  localparam int AW       = $clog2(WIN_BYTES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               msi_mode,
  input  logic               dev_ready,
  input  logic [ID_W-1:0]    node_id,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [AW-1:0]      bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               db_valid,
  input  logic               db_ready,
  output logic [15:0]        db_dest,
  output logic [15:0]        db_vector,
  input  logic               ev_valid,
  output logic               ev_ready,
  input  logic [15:0]        ev_vector,
  output logic               irq_pin,
  output logic [NUM_VEC-1:0] msi_pulse,
  output logic               vec_err
);
  dec_t              dec;
  logic              wr_hit, mask_we, stat_clr, bell_we;
  logic [WORD_W-1:0] mask_q, pos_val, rd_mux;
  logic              status_q;
  logic [FIELD_W-1:0] out_vec;

  dbell_decode #(.AW(AW)) u_dec (.addr(bus_addr), .dec(dec));

  assign wr_hit   = bus_wr & dec.hit;
  assign mask_we  = wr_hit & (dec.sel == SEL_MASK);
  assign stat_clr = wr_hit & (dec.sel == SEL_STAT);
  assign bell_we  = wr_hit & (dec.sel == SEL_BELL);
  assign ev_ready = 1'b1;

  // Pin mode discards the vector field of an outgoing request.
  assign out_vec  = msi_mode ? bus_wdata[15:0] : '0;
  assign pos_val  = dev_ready ? WORD_W'(node_id) : '1;

  dbell_irq #(.NUM_VEC(NUM_VEC)) u_irq (
    .clk(clk), .rst_n(rst_n), .msi_mode(msi_mode),
    .mask_we(mask_we), .mask_wdata(bus_wdata), .stat_clr(stat_clr),
    .ev_valid(ev_valid), .ev_vector(ev_vector),
    .mask_q(mask_q), .status_q(status_q), .irq_pin(irq_pin),
    .msi_pulse(msi_pulse), .vec_err(vec_err)
  );

  dbell_outq u_outq (
    .clk(clk), .rst_n(rst_n), .load(bell_we),
    .dest_in(bus_wdata[31:16]), .vec_in(out_vec),
    .db_ready(db_ready), .db_valid(db_valid),
    .db_dest(db_dest), .db_vector(db_vector)
  );

  always_comb begin
    rd_mux = '0;
    if (dec.hit) begin
      unique case (dec.sel)
        SEL_MASK: rd_mux = mask_q;
        SEL_STAT: rd_mux = WORD_W'(status_q);
        SEL_POS:  rd_mux = pos_val;
        SEL_BELL: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  a_r2_outside_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !dec.hit) |=> (bus_rdata == '0));
  a_r6_unready_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && dec.hit && dec.sel == SEL_POS && !dev_ready) |=> (bus_rdata == '1));
  a_r11_never_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ready);
endmodule

// File: tb/test_shm_doorbell_regs.sv
module test_shm_doorbell_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msi_mode = 1'b0, dev_ready = 1'b1;
  logic [15:0] node_id = 16'h0005;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        db_valid, db_ready = 1'b0;
  logic [15:0] db_dest, db_vector;
  logic        ev_valid = 1'b0, ev_ready;
  logic [15:0] ev_vector = '0;
  logic        irq_pin, vec_err;
  logic [7:0]  msi_pulse;
  int          checks = 0, errors = 0;
  logic        done = 1'b0;
  logic [31:0] rd;

  always #5 clk = ~clk;

  shm_doorbell_regs i_shm_doorbell_regs (
    .clk(clk), .rst_n(rst_n), .msi_mode(msi_mode), .dev_ready(dev_ready),
    .node_id(node_id), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .db_valid(db_valid),
    .db_ready(db_ready), .db_dest(db_dest), .db_vector(db_vector),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_vector(ev_vector),
    .irq_pin(irq_pin), .msi_pulse(msi_pulse), .vec_err(vec_err)
  );

  typedef struct packed {
    logic        wr;
    logic [9:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } op_t;

  // Pin mode, ready, node 5.
  localparam int NOPS = 14;
  localparam op_t OPS [NOPS] = '{
    '{1'b0, 10'h000, 32'h0,        32'h0,        4'd3},  // R3 mask reset
    '{1'b0, 10'h004, 32'h0,        32'h0,        4'd3},  // R3 status reset
    '{1'b1, 10'h000, 32'hA5A50001, 32'h0,        4'd1},
    '{1'b0, 10'h000, 32'h0,        32'hA5A50001, 4'd1},  // R1 mask readback
    '{1'b0, 10'h002, 32'h0,        32'hA5A50001, 4'd1},  // R1 low bits ignored
    '{1'b0, 10'h008, 32'h0,        32'h00000005, 4'd6},  // R6 position
    '{1'b1, 10'h008, 32'h00001234, 32'h0,        4'd6},
    '{1'b0, 10'h008, 32'h0,        32'h00000005, 4'd6},  // R6 write ignored
    '{1'b0, 10'h00C, 32'h0,        32'h0,        4'd1},  // R1 doorbell reads 0
    '{1'b1, 10'h010, 32'hFFFFFFFF, 32'h0,        4'd2},
    '{1'b0, 10'h010, 32'h0,        32'h0,        4'd2},  // R2 outside
    '{1'b1, 10'h3F0, 32'h00000000, 32'h0,        4'd2},  // R2 write outside, mask kept
    '{1'b0, 10'h000, 32'h0,        32'hA5A50001, 4'd2},
    '{1'b0, 10'h3FC, 32'h0,        32'h0,        4'd2}   // R2 last word
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic event_in(input logic [15:0] v);
    @(negedge clk); ev_valid = 1'b1; ev_vector = v;
    @(negedge clk); ev_valid = 1'b0;
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R3 irq_pin", {31'b0, irq_pin}, 32'h0);
    chk("R3 db_valid", {31'b0, db_valid}, 32'h0);
    chk("R3 msi_pulse", {24'b0, msi_pulse}, 32'h0);
    chk("R3 vec_err", {31'b0, vec_err}, 32'h0);
    chk("R11 ev_ready", {31'b0, ev_ready}, 32'h1);

    for (int i = 0; i < NOPS; i++) begin
      if (OPS[i].wr) wr_reg(OPS[i].addr, OPS[i].data);
      else begin
        rd_reg(OPS[i].addr, rd);
        chk($sformatf("R%0d table op %0d", OPS[i].req, i), rd, OPS[i].exp);
      end
    end

    // R4/R5: mask bit 0 is set from the table; clear it, keep the upper bits.
    wr_reg(10'h000, 32'hFFFFFFFE);
    event_in(16'h1234);
    rd_reg(10'h004, rd);
    chk("R4 status set", rd, 32'h1);
    chk("R5 upper mask bits no effect", {31'b0, irq_pin}, 32'h0);
    wr_reg(10'h000, 32'h00000001);
    @(negedge clk);
    chk("R5 irq after unmask", {31'b0, irq_pin}, 32'h1);
    wr_reg(10'h004, 32'h0);
    chk("R5 irq held one more cycle", {31'b0, irq_pin}, 32'h1);
    @(negedge clk);
    chk("R5 irq after clear", {31'b0, irq_pin}, 32'h0);
    rd_reg(10'h004, rd);
    chk("R4 status cleared", rd, 32'h0);
    // R4: event and clear in the same cycle, event wins.
    @(negedge clk); ev_valid = 1'b1; bus_wr = 1'b1; bus_addr = 10'h004; bus_wdata = '1;
    @(negedge clk); ev_valid = 1'b0; bus_wr = 1'b0;
    rd_reg(10'h004, rd);
    chk("R4 event beats clear", rd, 32'h1);

    // R6: not ready.
    dev_ready = 1'b0;
    rd_reg(10'h008, rd);
    chk("R6 unready all ones", rd, 32'hFFFFFFFF);
    dev_ready = 1'b1;

    // R7/R8: pin mode doorbell, held.
    wr_reg(10'h00C, 32'h0003BEEF);
    chk("R7 valid", {31'b0, db_valid}, 32'h1);
    chk("R7 dest", {16'b0, db_dest}, 32'h3);
    chk("R7 pin vector zero", {16'b0, db_vector}, 32'h0);
    msi_mode = 1'b1;
    wr_reg(10'h00C, 32'h00070002);
    chk("R8 held dest", {16'b0, db_dest}, 32'h3);
    chk("R8 held valid", {31'b0, db_valid}, 32'h1);
    @(negedge clk); db_ready = 1'b1; bus_wr = 1'b1; bus_addr = 10'h00C; bus_wdata = 32'h00090004;
    @(negedge clk); bus_wr = 1'b0;
    chk("R8 load on accept dest", {16'b0, db_dest}, 32'h9);
    chk("R7 msi vector", {16'b0, db_vector}, 32'h4);
    chk("R8 still valid", {31'b0, db_valid}, 32'h1);
    @(negedge clk);
    chk("R8 drained", {31'b0, db_valid}, 32'h0);
    db_ready = 1'b0;

    // R9: status is 1 from the R4 test; vector mode must keep it.
    event_in(16'd5);
    chk("R9 pulse bit", {24'b0, msi_pulse}, 32'h20);
    @(negedge clk);
    chk("R9 pulse one cycle", {24'b0, msi_pulse}, 32'h0);
    rd_reg(10'h004, rd);
    chk("R9 status unchanged", rd, 32'h1);
    chk("R10 no err yet", {31'b0, vec_err}, 32'h0);

    // R10: out of range.
    event_in(16'd8);
    chk("R10 dropped", {24'b0, msi_pulse}, 32'h0);
    chk("R10 err set", {31'b0, vec_err}, 32'h1);
    event_in(16'd0);
    chk("R9 vector 0", {24'b0, msi_pulse}, 32'h01);
    chk("R10 err sticky", {31'b0, vec_err}, 32'h1);

    done = 1'b1;
    finish_run();
  end
endmodule